// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address for one requested kind of access (read, write, execute, or any mix of them). A requester presents the address together with a privilege level (kernel or user) and a flag that selects physical mode. Three cases are settled without touching memory:

- In physical mode the address passes straight through.
- An address that is not sign-extended from its top implemented bit is refused.
- A negative address inside the kernel direct-mapped window is relocated by bit arithmetic.

Any other address is translated by reading three levels of 8-byte table entries. The first read starts from a table base input. Each read goes out over a simple port that carries one outstanding 64-bit read. Each level either continues the walk or stops it with a fault.

Each translation ends in a one-cycle response. It carries either a physical address with its granted permissions, or a 3-bit fault code. The fault codes are: 0 none, 1 access violation, 2 entry not valid, 3 fault-on-read, 4 fault-on-write, 5 fault-on-execute.

Entry bits:

| Entry bit | Meaning |
|---|---|
| 0 | valid |
| 1 | fault-on-read |
| 2 | fault-on-write |
| 3 | fault-on-execute |
| 8 | kernel read |
| 9 | user read |
| 12 | kernel write |
| 13 | user write |
| 63:32 | frame number |

The access and permission vectors use bit 0 for read, bit 1 for write and bit 2 for execute.

Top module: `ptw_xlate`

## Requirements
- R1: With `req_phys` set, the response gives `rsp_paddr` equal to the request address, `rsp_perm` 3'b111 and fault 0. It makes no memory read and arrives one cycle after acceptance.
- R2: Outside physical mode, an address whose bits 63:43 are not all equal gives fault 1 (access violation) with paddr 0 and perm 0. It makes no memory read.
- R3: A user request (`req_user`=1) to a superpage address gives fault 1 with paddr 0 and perm 0, and makes no memory read. A superpage address has bit 63 set and bits 42:41 equal to 2'b10.
- R4: A kernel request to a superpage address gives paddr = address bits 39:0, with address bit 40 moved to paddr bit 43 and paddr bits 42:40 and 63:44 zero. It gives perm 3'b111 and fault 0, makes no memory read, and responds one cycle after acceptance.
- R5: A walk reads the level 1, 2 and 3 entries in that order. Each read address is the current table base plus 8 times a 10-bit index. The index is address bits 42:33 at level 1, bits 32:23 at level 2 and bits 22:13 at level 3. The first base is `pt_base`, sampled at acceptance.
- R6: The next table base, and the final frame address, is entry bits 63:32 shifted left by 13.
- R7: At level 1 or 2, an entry with bit 0 clear ends the walk with fault 2, paddr 0 and perm 0. An entry with bit 8 clear ends it with fault 1, paddr 0 and perm 0.
- R8: A level-3 entry with bit 0 clear gives fault 2, perm 0, and paddr set to the frame address of that entry.
- R9: At level 3, read and execute are granted by bit 8 (kernel) or bit 9 (user), and write by bit 12 (kernel) or bit 13 (user). If the request is nonzero and shares no bit with the grant, the fault is 1, `rsp_perm` is the grant and paddr is the frame.
- R10: Entry bits 1, 2 and 3 remove read, write and execute from the grant. If the remaining grant then shares no bit with the request, the fault is 5 when execute was requested, otherwise 4 when write was requested, otherwise 3. `rsp_perm` is the remaining grant and paddr is the frame.
- R11: A request with access 3'b000 that reaches a valid level-3 entry never faults, whatever that entry grants.
- R12: `req_ready` is high only while no translation is in progress. `rsp_valid` is a single-cycle pulse per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_vaddr | input | 64 | Virtual address |
| req_access | input | 3 | Needed access: bit0 read, bit1 write, bit2 execute |
| req_user | input | 1 | 0 kernel privilege, 1 user privilege |
| req_phys | input | 1 | Physical mode, no translation |
| pt_base | input | 64 | Level-1 table base address |
| mem_req_valid | output | 1 | One-cycle table read request |
| mem_req_addr | output | 64 | Table entry address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Table entry read |
| rsp_valid | output | 1 | Result pulse |
| rsp_paddr | output | 64 | Physical address |
| rsp_perm | output | 3 | Granted access: bit0 read, bit1 write, bit2 execute |
| rsp_fault | output | 3 | Fault code |

## Verification
On every cycle the assertions check the following:
- the physical-mode pass-through and the refusal of non-canonical addresses;
- the single-cycle shape of memory requests and responses;
- that the block never reports busy-ready;
- that a fault-free answer covers the requested access, and that a fault-on answer does not.

The bench's scenarios are needed for the rest:
- the table walk order and the entry addresses;
- the superpage bit relocation;
- the per-level stop conditions;
- the priority among the three fault-on codes;
- the zero-access case.

A behavioural model with its own memory image predicts each result and each read address for these scenarios, with a read latency from 0 to 3 cycles.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // entry bit positions; neighbouring software builds entries with these
  localparam int PTE_VLD  = 0;
  localparam int PTE_FOR  = 1;
  localparam int PTE_FOW  = 2;
  localparam int PTE_FOE  = 3;
  localparam int PTE_KRD  = 8;
  localparam int PTE_KWR  = 12;
  localparam int PTE_FRM  = 32;

  // access / permission vector positions
  localparam int ACC_RD = 0;
  localparam int ACC_WR = 1;
  localparam int ACC_EX = 2;

  // kernel direct-map window: physical low part and relocated bit
  localparam int SP_LOW_BITS = 40;
  localparam int SP_HI_DST   = 43;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_ACCESS  = 3'd1,
    FLT_INVALID = 3'd2,
    FLT_ON_RD   = 3'd3,
    FLT_ON_WR   = 3'd4,
    FLT_ON_EX   = 3'd5
  } flt_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2,
    S_DONE  = 2'd3
  } walk_st_e;

  typedef struct packed {
    logic [63:0] paddr;
    logic [2:0]  perm;
    flt_e        fault;
  } xlate_res_t;

endpackage

// File: rtl/ptw_rst_sync.sv
module ptw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/ptw_shortcut.sv
module ptw_shortcut
  import ptw_pkg::*;
#(
  parameter int VA_BITS = 43
) (
  input  logic        phys_i,
  input  logic        user_i,
  input  logic [63:0] vaddr_i,
  output logic        done_o,
  output xlate_res_t  res_o
);

  localparam int HI_W = 64 - VA_BITS;

  logic canon;
  logic in_window;

  assign canon     = (vaddr_i[63:VA_BITS] == {HI_W{vaddr_i[63]}});
  assign in_window = vaddr_i[63] && (vaddr_i[VA_BITS-1:VA_BITS-2] == 2'b10);

  always_comb begin
    done_o = 1'b1;
    res_o  = '{paddr: '0, perm: 3'b000, fault: FLT_ACCESS};
    if (phys_i) begin
      res_o = '{paddr: vaddr_i, perm: 3'b111, fault: FLT_NONE};
    end else if (!canon) begin
      res_o.fault = FLT_ACCESS;
    end else if (in_window) begin
      if (!user_i) begin
        res_o.paddr                       = '0;
        res_o.paddr[SP_LOW_BITS-1:0]      = vaddr_i[SP_LOW_BITS-1:0];
        res_o.paddr[SP_HI_DST]            = vaddr_i[SP_LOW_BITS];
        res_o.perm                        = 3'b111;
        res_o.fault                       = FLT_NONE;
      end
    end else begin
      done_o = 1'b0;
    end
  end

endmodule

// File: rtl/ptw_idx_gen.sv
module ptw_idx_gen #(
  parameter int PG_BITS  = 13,
  parameter int IDX_BITS = 10,
  parameter int LEVELS   = 3,
  parameter int LVL_W    = 2
) (
  input  logic [IDX_BITS*LEVELS-1:0] walk_bits_i,
  input  logic [63:0]                base_i,
  input  logic [LVL_W-1:0]           lvl_i,
  output logic [63:0]                entry_addr_o
);

  logic [IDX_BITS-1:0] idx [LEVELS];
  logic [IDX_BITS-1:0] idx_sel;

  // level 0 takes the most significant slice
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx[g] = walk_bits_i[IDX_BITS*(LEVELS-1-g) +: IDX_BITS];
  end

  always_comb begin
    idx_sel = '0;
    for (int k = 0; k < LEVELS; k++) begin
      if (lvl_i == LVL_W'(k)) idx_sel = idx[k];
    end
  end

  assign entry_addr_o = base_i + (64'(idx_sel) << 3);

endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
  import ptw_pkg::*;
#(
  parameter int PG_BITS = 13
) (
  input  logic [63:0] pte_i,
  input  logic        last_i,
  input  logic        user_i,
  input  logic [2:0]  acc_i,
  output logic        stop_o,
  output logic [63:0] next_base_o,
  output xlate_res_t  res_o
);

  logic [63:0] frame;
  logic        rd_ok;
  logic        wr_ok;
  logic [2:0]  grant;
  logic [2:0]  kept;
  logic [2:0]  fo_mask;
  logic        unused_pte;

  assign frame       = 64'(pte_i[63:PTE_FRM]) << PG_BITS;
  assign next_base_o = frame;
  assign rd_ok       = user_i ? pte_i[PTE_KRD+1] : pte_i[PTE_KRD];
  assign wr_ok       = user_i ? pte_i[PTE_KWR+1] : pte_i[PTE_KWR];
  assign fo_mask     = {pte_i[PTE_FOE], pte_i[PTE_FOW], pte_i[PTE_FOR]};
  assign unused_pte  = ^{pte_i[31:14], pte_i[11:10], pte_i[7:4]};

  always_comb begin
    grant          = '0;
    grant[ACC_RD]  = rd_ok;
    grant[ACC_WR]  = wr_ok;
    grant[ACC_EX]  = rd_ok;
    kept           = grant & ~fo_mask;
  end

  always_comb begin
    stop_o = 1'b1;
    res_o  = '{paddr: '0, perm: 3'b000, fault: FLT_NONE};
    if (!last_i) begin
      if (!pte_i[PTE_VLD])      res_o.fault = FLT_INVALID;
      else if (!pte_i[PTE_KRD]) res_o.fault = FLT_ACCESS;
      else                      stop_o      = 1'b0;
    end else begin
      res_o.paddr = frame;
      if (!pte_i[PTE_VLD]) begin
        res_o.fault = FLT_INVALID;
      end else if ((acc_i != 3'b000) && ((grant & acc_i) == 3'b000)) begin
        res_o.perm  = grant;
        res_o.fault = FLT_ACCESS;
      end else begin
        res_o.perm = kept;
        if ((kept & acc_i) == 3'b000) begin
          if (acc_i[ACC_EX])      res_o.fault = FLT_ON_EX;
          else if (acc_i[ACC_WR]) res_o.fault = FLT_ON_WR;
          else if (acc_i[ACC_RD]) res_o.fault = FLT_ON_RD;
        end
      end
    end
  end

endmodule

// File: rtl/ptw_xlate.sv
module ptw_xlate
  import ptw_pkg::*;
#(
  parameter int VA_BITS  = 43,
  parameter int PG_BITS  = 13,
  parameter int IDX_BITS = 10,
  parameter int LEVELS   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [63:0] req_vaddr,
  input  logic [2:0]  req_access,
  input  logic        req_user,
  input  logic        req_phys,
  input  logic [63:0] pt_base,
  output logic        mem_req_valid,
  output logic [63:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic        rsp_valid,
  output logic [63:0] rsp_paddr,
  output logic [2:0]  rsp_perm,
  output logic [2:0]  rsp_fault
);

  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int WALK_W = IDX_BITS * LEVELS;
  localparam int WALK_L = PG_BITS;
  localparam int HI_W   = 64 - VA_BITS;

  logic                rst_n_s;
  walk_st_e            st_q, st_d;
  logic [LVL_W-1:0]    lvl_q, lvl_d;
  logic [WALK_W-1:0]   walk_q;
  logic [2:0]          acc_q;
  logic                user_q;
  logic [63:0]         base_q;
  xlate_res_t          res_q, res_d;

  logic                accept;
  logic                sc_done;
  xlate_res_t          sc_res;
  logic                chk_stop;
  logic [63:0]         chk_next;
  xlate_res_t          chk_res;
  logic                last_lvl;
  logic                rsp_in;
  logic                ld_req;
  logic                ld_base;
  logic                ld_res;

  ptw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  ptw_shortcut #(.VA_BITS(VA_BITS)) u_short (
    .phys_i  (req_phys),
    .user_i  (req_user),
    .vaddr_i (req_vaddr),
    .done_o  (sc_done),
    .res_o   (sc_res)
  );

  ptw_idx_gen #(
    .PG_BITS  (PG_BITS),
    .IDX_BITS (IDX_BITS),
    .LEVELS   (LEVELS),
    .LVL_W    (LVL_W)
  ) u_idx (
    .walk_bits_i  (walk_q),
    .base_i       (base_q),
    .lvl_i        (lvl_q),
    .entry_addr_o (mem_req_addr)
  );

  assign last_lvl = (lvl_q == LVL_W'(LEVELS-1));

  ptw_pte_check #(.PG_BITS(PG_BITS)) u_chk (
    .pte_i       (mem_rsp_data),
    .last_i      (last_lvl),
    .user_i      (user_q),
    .acc_i       (acc_q),
    .stop_o      (chk_stop),
    .next_base_o (chk_next),
    .res_o       (chk_res)
  );

  assign accept = req_valid && (st_q == S_IDLE);
  assign rsp_in = (st_q == S_WAIT) && mem_rsp_valid;

  // next-state logic
  always_comb begin
    st_d    = st_q;
    lvl_d   = lvl_q;
    ld_req  = 1'b0;
    ld_base = 1'b0;
    ld_res  = 1'b0;
    res_d   = chk_res;
    unique case (st_q)
      S_IDLE: begin
        if (req_valid) begin
          ld_req = 1'b1;
          lvl_d  = '0;
          if (sc_done) begin
            st_d   = S_DONE;
            ld_res = 1'b1;
            res_d  = sc_res;
          end else begin
            st_d = S_ISSUE;
          end
        end
      end
      S_ISSUE: st_d = S_WAIT;
      S_WAIT: begin
        if (mem_rsp_valid) begin
          if (chk_stop) begin
            st_d   = S_DONE;
            ld_res = 1'b1;
          end else begin
            st_d    = S_ISSUE;
            lvl_d   = lvl_q + 1'b1;
            ld_base = 1'b1;
          end
        end
      end
      S_DONE: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q  <= S_IDLE;
      lvl_q <= '0;
    end else begin
      st_q  <= st_d;
      lvl_q <= lvl_d;
    end
  end

  // datapath registers with explicit enables
  always_ff @(posedge clk) begin
    if (ld_req) begin
      walk_q <= req_vaddr[WALK_L +: WALK_W];
      acc_q  <= req_access;
      user_q <= req_user;
    end
    if (ld_req)       base_q <= pt_base;
    else if (ld_base) base_q <= chk_next;
    if (ld_res)       res_q  <= res_d;
  end

  assign req_ready     = (st_q == S_IDLE);
  assign mem_req_valid = (st_q == S_ISSUE);
  assign rsp_valid     = (st_q == S_DONE);
  assign rsp_paddr     = res_q.paddr;
  assign rsp_perm      = res_q.perm;
  assign rsp_fault     = res_q.fault;

  AST_PHYS_BYPASS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (accept && req_phys) |=> (rsp_valid && rsp_paddr == $past(req_vaddr)
                              && rsp_perm == 3'b111 && rsp_fault == FLT_NONE)); // R1

  AST_NONCANON_REFUSED: assert property (@(posedge clk) disable iff (!rst_n_s)
    (accept && !req_phys && (req_vaddr[63:VA_BITS] != {HI_W{req_vaddr[63]}}))
      |=> (rsp_valid && rsp_fault == FLT_ACCESS && rsp_paddr == 64'd0)); // R2

  AST_MEMREQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_req_valid |=> !mem_req_valid); // R5

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_valid |=> !rsp_valid); // R12

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_req_valid || rsp_in) |-> !req_ready); // R12

  AST_GRANT_COVERS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rsp_valid && rsp_fault == FLT_NONE && acc_q != 3'b000)
      |-> ((rsp_perm & acc_q) != 3'b000)); // R9

  AST_FAULTON_LOST: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rsp_valid && (rsp_fault == FLT_ON_RD || rsp_fault == FLT_ON_WR || rsp_fault == FLT_ON_EX))
      |-> ((rsp_perm & acc_q) == 3'b000)); // R10

endmodule

// File: tb/ptw_xlate_tb.sv
`timescale 1ns/1ps
module ptw_xlate_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [63:0] req_vaddr;
  logic [2:0]  req_access;
  logic        req_user;
  logic        req_phys;
  logic [63:0] pt_base;
  logic        mem_req_valid;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        rsp_valid;
  logic [63:0] rsp_paddr;
  logic [2:0]  rsp_perm;
  logic [2:0]  rsp_fault;

  int checks = 0;
  int errors = 0;

  logic [63:0] mem [logic [63:0]];
  logic [63:0] exp_q [$];
  int          nreads;
  int          mem_lat;
  logic        pend;
  int          cnt;
  logic [63:0] pend_addr;

  localparam logic [63:0] BASE = 64'h0010_0000;
  localparam logic [63:0] T2   = 64'h0020_0000;
  localparam logic [63:0] T3   = 64'h0040_0000;
  localparam logic [11:0] F_V = 12'h001, F_FR = 12'h002, F_FW = 12'h004, F_FE = 12'h008,
                          F_KR = 12'h100, F_UR = 12'h200;
  localparam logic [15:0] F_KW = 16'h1000, F_UW = 16'h2000;

  ptw_xlate u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_access(req_access), .req_user(req_user), .req_phys(req_phys),
    .pt_base(pt_base),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm), .rsp_fault(rsp_fault)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [63:0] rd(input logic [63:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'd0;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory responder: one read at a time, latency mem_lat
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rd(pend_addr);
        pend          = 1'b0;
      end else cnt = cnt - 1;
    end
    if (mem_req_valid) begin
      nreads++;
      pend      = 1'b1;
      cnt       = mem_lat;
      pend_addr = mem_req_addr;
      if (exp_q.size() == 0) chk("R5", "unexpected table read", mem_req_addr, 64'hx);
      else chk("R5", "table read address", mem_req_addr, exp_q.pop_front());
    end
  end

  // behavioural reference
  task automatic model(input logic [63:0] va, input logic [2:0] acc, input logic user,
                       input logic phys, input logic [63:0] base,
                       output logic [63:0] pa, output logic [2:0] pm, output logic [2:0] ft,
                       output int n);
    logic [63:0] b, pte, a;
    logic [2:0]  g;
    pa = 0; pm = 0; ft = 0; n = 0; b = base;
    if (phys) begin pa = va; pm = 3'b111; return; end
    if (va[63:43] != {21{va[63]}}) begin ft = 1; return; end
    if (va[63] && va[42:41] == 2'b10) begin
      if (user) begin ft = 1; return; end
      pa = {20'd0, va[40], 3'd0, va[39:0]}; pm = 3'b111; return;
    end
    for (int l = 0; l < 3; l++) begin
      a = b + 64'(((va >> (13 + 10*(2-l))) & 64'h3ff) * 8);
      exp_q.push_back(a);
      n++;
      pte = rd(a);
      if (l < 2) begin
        if (!pte[0]) begin ft = 2; return; end
        if (!pte[8]) begin ft = 1; return; end
        b = {19'd0, pte[63:32], 13'd0};
      end else begin
        pa = {19'd0, pte[63:32], 13'd0};
        if (!pte[0]) begin ft = 2; return; end
        g = {pte[8+user], pte[12+user], pte[8+user]};
        if (acc != 0 && (g & acc) == 0) begin pm = g; ft = 1; return; end
        pm = g & ~pte[3:1];
        if ((pm & acc) == 0) ft = acc[2] ? 3'd5 : acc[1] ? 3'd4 : acc[0] ? 3'd3 : 3'd0;
      end
    end
  endtask

  function automatic logic [63:0] mkva(input int i1, input int i2, input int i3, input int off);
    return (64'(i1) << 33) | (64'(i2) << 23) | (64'(i3) << 13) | 64'(off);
  endfunction

  task automatic map3(input int i1, input int i2, input int i3,
                      input logic [15:0] f1, input logic [15:0] f2,
                      input logic [31:0] frm, input logic [15:0] f3);
    mem[BASE + 64'(i1*8)] = {32'h100, 16'd0, f1};
    mem[T2 + 64'(i2*8)]   = {32'h200, 16'd0, f2};
    mem[T3 + 64'(i3*8)]   = {frm, 16'd0, f3};
  endtask

  task automatic xlate(input string req, input logic [63:0] va, input logic [2:0] acc,
                       input logic user, input logic phys, input int lat);
    logic [63:0] e_pa; logic [2:0] e_pm, e_ft; int e_n; int cyc;
    model(va, acc, user, phys, BASE, e_pa, e_pm, e_ft, e_n);
    @(negedge clk);
    mem_lat = lat; nreads = 0;
    chk("R12", "ready before request", req_ready, 1'b1);
    req_valid = 1'b1; req_vaddr = va; req_access = acc; req_user = user; req_phys = phys;
    @(negedge clk);
    req_valid = 1'b0; req_vaddr = '0; pt_base = 64'hdead_0000;
    cyc = 1;
    while (!rsp_valid && cyc < 200) begin
      if (req_ready) chk("R12", "ready while busy", req_ready, 1'b0);
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 200) begin
      chk(req, "response timeout", 1'b0, 1'b1);
    end else begin
      chk(req, "paddr", rsp_paddr, e_pa);
      chk(req, "perm",  64'(rsp_perm), 64'(e_pm));
      chk(req, "fault", 64'(rsp_fault), 64'(e_ft));
      chk(req, "read count", 64'(nreads), 64'(e_n));
      if (e_n == 0) chk(req, "shortcut latency", 64'(cyc), 64'd1);
    end
    exp_q.delete();
    @(negedge clk);
    chk("R12", "response pulse width", rsp_valid, 1'b0);
    pt_base = BASE;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_vaddr = 0; req_access = 0; req_user = 0; req_phys = 0;
    pt_base = BASE; mem_rsp_valid = 0; mem_rsp_data = 0; pend = 0; cnt = 0; mem_lat = 0;
    nreads = 0; pend_addr = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12", "reset ready", req_ready, 1'b1);
    chk("R12", "reset rsp_valid", rsp_valid, 1'b0);
    chk("R5", "reset mem_req_valid", mem_req_valid, 1'b0);

    // R1 physical mode, including a non-canonical address
    xlate("R1", 64'h8000_1234_5678_9abc, 3'b010, 1'b1, 1'b1, 0);
    xlate("R1", 64'h0000_0000_0000_0040, 3'b001, 1'b0, 1'b1, 0);
    // R2 sign-extension refusal
    xlate("R2", 64'h0000_0800_0000_0000, 3'b001, 1'b0, 1'b0, 0);
    xlate("R2", 64'h8000_0000_0000_0000, 3'b001, 1'b0, 1'b0, 0);
    // R3 / R4 superpage
    xlate("R3", 64'hFFFF_FD12_3456_789A, 3'b001, 1'b1, 1'b0, 0);
    xlate("R4", 64'hFFFF_FD12_3456_789A, 3'b010, 1'b0, 1'b0, 0);
    xlate("R4", 64'hFFFF_FC00_0000_1000, 3'b100, 1'b0, 1'b0, 0);
    // R5 / R6 successful walks, varied latency
    map3(3, 7, 11, F_KR | F_V, F_KR | F_V, 32'h0000_1234, F_KR | F_KW | F_V);
    xlate("R5", mkva(3, 7, 11, 16'h0abc), 3'b001, 1'b0, 1'b0, 0);
    xlate("R6", mkva(3, 7, 11, 16'h0008), 3'b010, 1'b0, 1'b0, 3);
    map3(1023, 1023, 1023, F_KR | F_V, F_KR | F_V, 32'hffff_ffff, F_KR | F_V);
    xlate("R5", mkva(1023, 1023, 1023, 16'h1fff), 3'b100, 1'b0, 1'b0, 2);
    // negative, bits 42:41 = 11 goes through the walk
    xlate("R5", 64'hFFFF_FE00_0000_0000, 3'b001, 1'b0, 1'b0, 1);
    // R7 level 1 / 2 stops
    map3(5, 9, 2, 16'h0000, F_KR | F_V, 32'h55, F_KR | F_V);
    xlate("R7", mkva(5, 9, 2, 0), 3'b001, 1'b0, 1'b0, 0);
    map3(5, 9, 2, F_V, F_KR | F_V, 32'h55, F_KR | F_V);
    xlate("R7", mkva(5, 9, 2, 0), 3'b001, 1'b0, 1'b0, 1);
    map3(5, 9, 2, F_KR | F_V, F_KR, 32'h55, F_KR | F_V);
    xlate("R7", mkva(5, 9, 2, 0), 3'b001, 1'b0, 1'b0, 0);
    map3(5, 9, 2, F_KR | F_V, F_V, 32'h55, F_KR | F_V);
    xlate("R7", mkva(5, 9, 2, 0), 3'b001, 1'b0, 1'b0, 2);
    // R8 level 3 invalid
    map3(6, 1, 4, F_KR | F_V, F_KR | F_V, 32'h0007_7777, F_KR | F_KW);
    xlate("R8", mkva(6, 1, 4, 0), 3'b001, 1'b0, 1'b0, 0);
    // R9 privilege selection
    map3(8, 8, 8, F_KR | F_V, F_KR | F_V, 32'h0000_0abc, F_UR | F_UW | F_V);
    xlate("R9", mkva(8, 8, 8, 0), 3'b010, 1'b1, 1'b0, 0);
    xlate("R9", mkva(8, 8, 8, 0), 3'b001, 1'b0, 1'b0, 1);
    map3(8, 8, 8, F_KR | F_V, F_KR | F_V, 32'h0000_0abc, F_KR | F_KW | F_V);
    xlate("R9", mkva(8, 8, 8, 0), 3'b010, 1'b1, 1'b0, 0);
    // R10 fault-on bits and priority
    map3(9, 9, 9, F_KR | F_V, F_KR | F_V, 32'h0000_0def, F_KR | F_KW | F_FR | F_V);
    xlate("R10", mkva(9, 9, 9, 0), 3'b001, 1'b0, 1'b0, 0);
    map3(9, 9, 9, F_KR | F_V, F_KR | F_V, 32'h0000_0def, F_KR | F_KW | F_FW | F_V);
    xlate("R10", mkva(9, 9, 9, 0), 3'b010, 1'b0, 1'b0, 0);
    xlate("R10", mkva(9, 9, 9, 0), 3'b001, 1'b0, 1'b0, 0);
    map3(9, 9, 9, F_KR | F_V, F_KR | F_V, 32'h0000_0def, F_KR | F_KW | F_FE | F_FW | F_V);
    xlate("R10", mkva(9, 9, 9, 0), 3'b110, 1'b0, 1'b0, 2);
    xlate("R10", mkva(9, 9, 9, 0), 3'b100, 1'b0, 1'b0, 0);
    // R11 zero access against an entry granting nothing
    map3(10, 10, 10, F_KR | F_V, F_KR | F_V, 32'h0000_0111, F_V | F_FR);
    xlate("R11", mkva(10, 10, 10, 0), 3'b000, 1'b0, 1'b0, 0);
    map3(10, 10, 10, F_KR | F_V, F_KR | F_V, 32'h0000_0111, F_KR | F_FR | F_FE | F_V);
    xlate("R11", mkva(10, 10, 10, 0), 3'b000, 1'b1, 1'b0, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule